// File: doc/BRIEF.md
# Receive Completion Interrupt Tracker

This block keeps track of completed receive work for several independent DMA channels and raises a level interrupt toward the host. When the DMA engine finishes a frame, it posts the address of that frame's final buffer descriptor to the channel's completion slot. The host answers by writing back the address of the last descriptor it has consumed.

Each channel interrupt is held in a register and follows a simple rule. A hardware post always raises the interrupt. A host write then lowers the interrupt only if the acknowledged address matches the address that hardware posted last. There is no separate clear bit. All channel levels are OR-ed onto one combined line. A readback port returns both stored addresses for a selected channel, so a host that processed nothing can re-write its previous acknowledgement.

Top module: `cmpl_irq_ctrl`

## Requirements
- R1: After the asynchronous active-low reset, every stored hardware address and host acknowledgement reads 0, and every channel interrupt and the combined line are 0.
- R2: A hardware write (`hw_we_i`=1) stores `hw_addr_i` into the completion slot of channel `hw_ch_i`. The value appears on `rd_hw_addr_o` for that channel after the next clock edge.
- R3: A hardware write without a host write to the same channel sets that channel's interrupt on the next edge. This happens whatever the address is, even when it equals the current acknowledgement.
- R4: A host write (`host_we_i`=1) stores `host_addr_i` as the acknowledgement of channel `host_ch_i`. The value appears on `rd_ack_addr_o` after the next clock edge.
- R5: A host write whose address equals the channel's stored hardware address clears that channel's interrupt on the next edge.
- R6: A host write whose address differs from the channel's stored hardware address leaves that channel's interrupt set on the next edge.
- R7: If the host re-writes its previous acknowledgement, the result follows the compare. The interrupt stays low if no new frame was posted, and stays high if a newer address was posted.
- R8: When hardware and host write the same channel in the same cycle, the hardware address is stored first and the host address is compared against it.
- R9: A write to one channel changes no other channel's addresses or interrupt.
- R10: `irq_o` is 1 exactly when at least one bit of `ch_irq_o` is 1. Bit i of `ch_irq_o` is channel i.
- R11: In cycles with no write to a channel, that channel's interrupt and stored addresses hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hw_we_i | input | 1 | DMA completion post strobe |
| hw_ch_i | input | 3 | Channel of the DMA post |
| hw_addr_i | input | 32 | Last descriptor address of the completed frame |
| host_we_i | input | 1 | Host acknowledgement strobe |
| host_ch_i | input | 3 | Channel being acknowledged |
| host_addr_i | input | 32 | Last descriptor address processed by the host |
| rd_ch_i | input | 3 | Channel selected for readback |
| rd_hw_addr_o | output | 32 | Stored hardware address of the selected channel |
| rd_ack_addr_o | output | 32 | Stored acknowledgement of the selected channel |
| ch_irq_o | output | 8 | Per-channel level interrupts |
| irq_o | output | 1 | OR of all channel interrupts |

## Verification
The hardest case is a hardware post and a host acknowledgement hitting the same channel in one cycle. The outcome then depends on the order of store and compare. The stimulus table drives such collisions twice. In one, the host value matches the new post, so the interrupt must drop. In the other, the host returns the stale address, so the interrupt must stay high. The table also posts an address equal to the existing acknowledgement, to show that the hardware write itself raises the line. It also pairs writes to two different channels in one cycle, to show the channels do not interfere.

// File: rtl/cmpl_irq_pkg.sv
package cmpl_irq_pkg;

  // Next interrupt level: a post raises it, an acknowledgement resolves it by compare.
  // The host compare is taken against the post of the same cycle if there is one.
  function automatic logic irq_next(input logic hw_we, input logic host_we,
                                    input logic host_match, input logic cur);
    logic nxt;
    nxt = cur;
    if (hw_we)   nxt = 1'b1;
    if (host_we) nxt = !host_match;
    return nxt;
  endfunction

endpackage

// File: rtl/cmpl_irq_chan.sv
module cmpl_irq_chan #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hw_we_i,
  input  logic [ADDR_W-1:0] hw_addr_i,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  output logic [ADDR_W-1:0] hw_ptr_o,
  output logic [ADDR_W-1:0] ack_ptr_o,
  output logic              irq_o
);
  import cmpl_irq_pkg::*;

  logic [ADDR_W-1:0] hw_ptr_q, ack_ptr_q, hw_ptr_d;
  logic              irq_q, host_match;

  // post lands first, host compares against the post-updated value
  assign hw_ptr_d   = hw_we_i ? hw_addr_i : hw_ptr_q;
  assign host_match = (host_addr_i == hw_ptr_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hw_ptr_q  <= '0;
      ack_ptr_q <= '0;
      irq_q     <= 1'b0;
    end else begin
      hw_ptr_q <= hw_ptr_d;
      if (host_we_i) ack_ptr_q <= host_addr_i;
      irq_q <= irq_next(hw_we_i, host_we_i, host_match, irq_q);
    end
  end

  assign hw_ptr_o  = hw_ptr_q;
  assign ack_ptr_o = ack_ptr_q;
  assign irq_o     = irq_q;

  assert_hw_raise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_we_i && !host_we_i) |=> irq_o);

  assert_ack_match_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_we_i && !hw_we_i && host_addr_i == hw_ptr_o) |=> !irq_o);

  assert_ack_differ_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_we_i && !hw_we_i && host_addr_i != hw_ptr_o) |=> irq_o);

  assert_same_cycle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_we_i && hw_we_i) |=> (irq_o == (hw_ptr_o != ack_ptr_o)));

  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hw_we_i && !host_we_i) |=> ($stable(irq_o) && $stable(hw_ptr_o) && $stable(ack_ptr_o)));

endmodule

// File: rtl/cmpl_irq_rd_mux.sv
module cmpl_irq_rd_mux #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [CH_W-1:0]   sel_i,
  input  logic [ADDR_W-1:0] hw_ptr_i  [NUM_CH],
  input  logic [ADDR_W-1:0] ack_ptr_i [NUM_CH],
  output logic [ADDR_W-1:0] hw_ptr_o,
  output logic [ADDR_W-1:0] ack_ptr_o
);
  always_comb begin
    hw_ptr_o  = '0;
    ack_ptr_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (sel_i == CH_W'(i)) begin
        hw_ptr_o  = hw_ptr_i[i];
        ack_ptr_o = ack_ptr_i[i];
      end
    end
  end
endmodule

// File: rtl/cmpl_irq_ctrl.sv
module cmpl_irq_ctrl #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hw_we_i,
  input  logic [CH_W-1:0]   hw_ch_i,
  input  logic [ADDR_W-1:0] hw_addr_i,
  input  logic              host_we_i,
  input  logic [CH_W-1:0]   host_ch_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [CH_W-1:0]   rd_ch_i,
  output logic [ADDR_W-1:0] rd_hw_addr_o,
  output logic [ADDR_W-1:0] rd_ack_addr_o,
  output logic [NUM_CH-1:0] ch_irq_o,
  output logic              irq_o
);
  logic [ADDR_W-1:0] hw_ptr  [NUM_CH];
  logic [ADDR_W-1:0] ack_ptr [NUM_CH];
  logic [NUM_CH-1:0] hw_sel, host_sel;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign hw_sel[g]   = hw_we_i   && (hw_ch_i   == CH_W'(g));
    assign host_sel[g] = host_we_i && (host_ch_i == CH_W'(g));

    cmpl_irq_chan #(.ADDR_W(ADDR_W)) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .hw_we_i     (hw_sel[g]),
      .hw_addr_i   (hw_addr_i),
      .host_we_i   (host_sel[g]),
      .host_addr_i (host_addr_i),
      .hw_ptr_o    (hw_ptr[g]),
      .ack_ptr_o   (ack_ptr[g]),
      .irq_o       (ch_irq_o[g])
    );
  end

  cmpl_irq_rd_mux #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_rd (
    .sel_i     (rd_ch_i),
    .hw_ptr_i  (hw_ptr),
    .ack_ptr_i (ack_ptr),
    .hw_ptr_o  (rd_hw_addr_o),
    .ack_ptr_o (rd_ack_addr_o)
  );

  assign irq_o = |ch_irq_o;

  // untouched channels keep their level
  assert_ch_isolation_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((ch_irq_o ^ $past(ch_irq_o)) & ~$past(hw_sel | host_sel)) == '0);

  assert_combined_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_irq_o == '0) |-> !irq_o);

endmodule

// File: tb/tb_cmpl_irq_ctrl.sv
module tb_cmpl_irq_ctrl;
  localparam int NUM_CH = 8;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              hw_we = 1'b0, host_we = 1'b0;
  logic [2:0]        hw_ch = '0, host_ch = '0, rd_ch = '0;
  logic [ADDR_W-1:0] hw_addr = '0, host_addr = '0;
  logic [ADDR_W-1:0] rd_hw, rd_ack;
  logic [NUM_CH-1:0] ch_irq;
  logic              irq;

  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  cmpl_irq_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .hw_we_i(hw_we), .hw_ch_i(hw_ch), .hw_addr_i(hw_addr),
    .host_we_i(host_we), .host_ch_i(host_ch), .host_addr_i(host_addr),
    .rd_ch_i(rd_ch), .rd_hw_addr_o(rd_hw), .rd_ack_addr_o(rd_ack),
    .ch_irq_o(ch_irq), .irq_o(irq)
  );

  typedef struct packed {
    logic        hw_we;
    logic [2:0]  hw_ch;
    logic [31:0] hw_addr;
    logic        host_we;
    logic [2:0]  host_ch;
    logic [31:0] host_addr;
    logic [7:0]  exp_irq;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 3'd0, 32'h100, 1'b0, 3'd0, 32'h000, 8'h01}, // R3 post ch0
    '{1'b0, 3'd0, 32'h000, 1'b1, 3'd0, 32'h0F0, 8'h01}, // R6 stale ack
    '{1'b0, 3'd0, 32'h000, 1'b1, 3'd0, 32'h100, 8'h00}, // R5 matching ack
    '{1'b0, 3'd0, 32'h000, 1'b1, 3'd0, 32'h100, 8'h00}, // R7 re-ack, nothing new
    '{1'b1, 3'd3, 32'h200, 1'b0, 3'd0, 32'h000, 8'h08}, // R9 ch3
    '{1'b1, 3'd5, 32'h300, 1'b0, 3'd0, 32'h000, 8'h28}, // R9 ch5
    '{1'b0, 3'd0, 32'h000, 1'b1, 3'd3, 32'h200, 8'h20}, // R9 clear ch3 only
    '{1'b1, 3'd0, 32'h100, 1'b0, 3'd0, 32'h000, 8'h21}, // R3 post equals ack
    '{1'b0, 3'd0, 32'h000, 1'b1, 3'd0, 32'h100, 8'h20}, // R5
    '{1'b1, 3'd5, 32'h340, 1'b1, 3'd5, 32'h340, 8'h00}, // R8 collide, match
    '{1'b1, 3'd7, 32'h500, 1'b1, 3'd7, 32'h300, 8'h80}, // R8 collide, stale
    '{1'b1, 3'd2, 32'h600, 1'b1, 3'd7, 32'h500, 8'h04}  // R9 two channels
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    hw_we = v.hw_we; hw_ch = v.hw_ch; hw_addr = v.hw_addr;
    host_we = v.host_we; host_ch = v.host_ch; host_addr = v.host_addr;
    @(negedge clk);
    hw_we = 1'b0; host_we = 1'b0;
  endtask

  task automatic rd_check(input logic [2:0] ch, input logic [31:0] ehw, input logic [31:0] eack);
    rd_ch = ch;
    #1;
    chk("R2 hw readback", rd_hw, ehw);
    chk("R4 ack readback", rd_ack, eack);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 irq vec", {24'd0, ch_irq}, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);
    rd_check(3'd4, 32'h0, 32'h0);
    @(negedge clk) rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i]);
      chk($sformatf("R3/R5/R6/R7/R8/R9 vec %0d", i), {24'd0, ch_irq}, {24'd0, TBL[i].exp_irq});
      chk($sformatf("R10 vec %0d", i), {31'd0, irq}, {31'd0, |TBL[i].exp_irq});
    end

    rd_check(3'd7, 32'h500, 32'h500);
    rd_check(3'd0, 32'h100, 32'h100);
    rd_check(3'd2, 32'h600, 32'h000);
    rd_check(3'd5, 32'h340, 32'h340);

    // R11 idle cycles hold
    repeat (5) @(negedge clk);
    chk("R11 hold", {24'd0, ch_irq}, 32'h04);
    rd_check(3'd2, 32'h600, 32'h000);

    // R7 host re-writes old ack after a new post: stays high
    apply('{1'b0, 3'd0, 32'h0, 1'b1, 3'd2, 32'h000, 8'h04});
    chk("R7 stale re-ack", {24'd0, ch_irq}, 32'h04);
    apply('{1'b0, 3'd0, 32'h0, 1'b1, 3'd2, 32'h600, 8'h00});
    chk("R5 final clear", {24'd0, ch_irq}, 32'h00);
    chk("R10 all low", {31'd0, irq}, 32'h0);

    // R1 reset mid-run
    apply('{1'b1, 3'd6, 32'hABC, 1'b0, 3'd0, 32'h0, 8'h40});
    chk("R3 ch6", {24'd0, ch_irq}, 32'h40);
    rst_ni = 1'b0;
    #1;
    chk("R1 async clear", {24'd0, ch_irq}, 32'h0);
    rd_check(3'd6, 32'h0, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule